// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Midpoint Start Validation

This block receives one asynchronous serial character stream on a line that idles high. It advances only on a 16x bit-rate enable pulse, `tick16`. When the line goes from high to low, the block treats this as a possible start bit. It keeps the start bit only if the line is still low at the middle of that bit. A short low glitch is therefore dropped, and the receiver goes back to searching for a start bit.

Once a start bit is confirmed, the block samples each following bit once, at its middle. It collects 5 to 8 data bits, least significant bit first. It then takes an optional parity bit and one stop bit. The finished character moves into a parallel receive buffer, and four status flags are updated: data ready, overrun, parity error and framing error.

A host uses the block with two read strobes, each one clock cycle wide:
- a data-read strobe takes the character and clears the data-ready flag;
- a status-read strobe clears the three error flags.

Top module: `uart_rx_core`

## Requirements
- R1: Synchronous reset clears `rx_data` to zero and clears all four status flags.
- R2: A start bit is accepted only if `rxd` was seen high and then low on a `tick16`, and is still low on the 8th `tick16` after that detection. A low pulse that ends before that sample is discarded, and the next valid frame is received normally.
- R3: After an accepted start, each later bit is sampled 16 `tick16` pulses after the previous sample.
  - Data arrives least significant bit first.
  - The data length is 5 + `cfg_len` bits.
  - The character appears in `rx_data` right-aligned, with the unused upper bits at zero.
- R4: Taking a character into the buffer sets `data_ready`. A `rd_data` pulse clears it. A `rd_status` pulse leaves it unchanged.
- R5: If a character is taken into the buffer while `data_ready` is still set and not being read in that cycle, `overrun_err` is set. The buffer then holds the newer character.
- R6: When `cfg_par_en` is 1, one parity bit follows the data.
  - With `cfg_par_odd` = 0, the data bits plus the parity bit must hold an even number of ones. With `cfg_par_odd` = 1, they must hold an odd number.
  - A mismatch sets `parity_err` at handoff.
  - When `cfg_par_en` is 0, no parity bit is expected and `parity_err` stays clear.
- R7: A stop bit sampled low sets `framing_err` at handoff. Only the first stop bit is checked, and the receiver then returns to start search.
- R8: A `rd_status` pulse clears `overrun_err`, `parity_err` and `framing_err`, unless a handoff in the same cycle sets them again. Until then, the error flags stay set across later good characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data length select: 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_data | input | 1 | Host read of the receive buffer (clears data ready) |
| rd_status | input | 1 | Host read of the status flags (clears error flags) |
| rx_data | output | 8 | Receive buffer, right-aligned character |
| data_ready | output | 1 | Unread character in buffer |
| overrun_err | output | 1 | Character overwritten before being read |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop bit sampled low |

## Verification
The assertions take three things for granted:
- the configuration inputs stay constant while a frame is in flight;
- the read strobes are one cycle wide;
- `tick16` is a single-cycle enable.

The handoff-related properties also rely on handoff happening only on a `tick16` cycle. The stimulus changes configuration only while the line has been idle for a full bit time. It drives `tick16` on every other clock and holds each serial bit for exactly 16 ticks, so the middle-of-bit samples never land near a bit edge. Read strobes are issued only well after the stop bit has been sampled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        SMP_NONE,
        SMP_DATA,
        SMP_PAR,
        SMP_STOP
    } smp_kind_t;

    typedef struct packed {
        smp_kind_t kind;
        logic      bit_val;
    } smp_t;

    typedef struct packed {
        logic framing;
        logic parity;
        logic overrun;
        logic ready;
    } rx_flags_t;

    function automatic logic [3:0] frame_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    // Shift register fills from the top; move the character down to bit 0.
    function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sr,
                                                     input logic [1:0] len);
        logic [2:0] sh;
        sh = 3'd3 - {1'b0, len};
        return sr >> sh;
    endfunction

    function automatic logic parity_bad(input logic [DATA_W-1:0] data,
                                        input logic pbit,
                                        input logic odd);
        return ((^data) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import uart_rx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int MAX_BITS      = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len,
    input  logic       par_en,
    output smp_t       smp
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam int BIT_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TICKS_PER_BIT - 1);

    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitn;
    logic             armed;
    logic [BIT_W-1:0] last_idx;
    logic             at_end;

    assign last_idx = BIT_W'(frame_bits(len) - 4'd1);
    assign at_end   = tick && (cnt == CNT_END);

    always_comb begin
        smp.bit_val = rxd;
        smp.kind    = SMP_NONE;
        if (at_end) begin
            case (state)
                ST_DATA: smp.kind = SMP_DATA;
                ST_PAR:  smp.kind = SMP_PAR;
                ST_STOP: smp.kind = SMP_STOP;
                default: smp.kind = SMP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            armed <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    armed <= rxd;
                    cnt   <= '0;
                    if (armed && !rxd)
                        state <= ST_START;
                end
                ST_START: begin
                    if (cnt == CNT_MID) begin
                        cnt  <= '0;
                        bitn <= '0;
                        if (!rxd) begin
                            state <= ST_DATA;
                        end else begin
                            state <= ST_IDLE;
                            armed <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == CNT_END) begin
                        cnt  <= '0;
                        bitn <= bitn + 1'b1;
                        if (bitn == last_idx)
                            state <= par_en ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == CNT_END) begin
                        cnt   <= '0;
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == CNT_END) begin
                        cnt   <= '0;
                        armed <= rxd;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_shift_reg.sv
module rx_shift_reg
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  smp_t              smp,
    input  logic [1:0]        len,
    output logic [DATA_W-1:0] data,
    output logic              par_bit
);
    logic [DATA_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            par_bit <= 1'b0;
        end else begin
            if (smp.kind == SMP_DATA)
                sr <= {smp.bit_val, sr[DATA_W-1:1]};
            if (smp.kind == SMP_PAR)
                par_bit <= smp.bit_val;
        end
    end

    assign data = align_data(sr, len);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  smp_t              smp,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_bit,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] buf_q,
    output rx_flags_t         flags
);
    logic handoff;
    assign handoff = (smp.kind == SMP_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            flags <= '0;
        end else if (handoff) begin
            buf_q         <= data_in;
            flags.ready   <= 1'b1;
            flags.overrun <= (flags.overrun & ~rd_status) | (flags.ready & ~rd_data);
            flags.parity  <= (flags.parity & ~rd_status)
                             | (par_en & parity_bad(data_in, par_bit, par_odd));
            flags.framing <= (flags.framing & ~rd_status) | ~smp.bit_val;
        end else begin
            if (rd_data)
                flags.ready <= 1'b0;
            if (rd_status) begin
                flags.overrun <= 1'b0;
                flags.parity  <= 1'b0;
                flags.framing <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_data,
    output logic       data_ready,
    output logic       overrun_err,
    output logic       parity_err,
    output logic       framing_err
);
    rx_cfg_t           cfg;
    smp_t              smp;
    logic [DATA_W-1:0] shift_data;
    logic              par_bit;
    rx_flags_t         flags;
    logic              handoff;

    assign cfg.len     = cfg_len;
    assign cfg.par_en  = cfg_par_en;
    assign cfg.par_odd = cfg_par_odd;
    assign handoff     = (smp.kind == SMP_STOP);

    rx_frame_ctl #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .MAX_BITS     (DATA_W)
    ) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .rxd   (rxd),
        .len   (cfg.len),
        .par_en(cfg.par_en),
        .smp   (smp)
    );

    rx_shift_reg u_shift (
        .clk    (clk),
        .rst    (rst),
        .smp    (smp),
        .len    (cfg.len),
        .data   (shift_data),
        .par_bit(par_bit)
    );

    rx_line_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .par_en   (cfg.par_en),
        .par_odd  (cfg.par_odd),
        .data_in  (shift_data),
        .par_bit  (par_bit),
        .rd_data  (rd_data),
        .rd_status(rd_status),
        .buf_q    (rx_data),
        .flags    (flags)
    );

    assign data_ready  = flags.ready;
    assign overrun_err = flags.overrun;
    assign parity_err  = flags.parity;
    assign framing_err = flags.framing;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick16,
    input logic       rd_data,
    input logic       rd_status,
    input logic       handoff,
    input logic [7:0] rx_data,
    input logic       data_ready,
    input logic       overrun_err,
    input logic       parity_err,
    input logic       framing_err
);
    // R4
    ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        handoff |=> data_ready);

    // R4
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !handoff) |=> !data_ready);

    // R4
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data && !handoff && data_ready) |=> data_ready);

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (handoff && data_ready && !rd_data) |=> overrun_err);

    // R5
    overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_err) |-> $past(handoff));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !handoff) |=> (!overrun_err && !parity_err && !framing_err));

    // R3
    buffer_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !handoff |=> $stable(rx_data));

    // R2
    handoff_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        handoff |-> tick16);
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick16     (tick16),
    .rd_data    (rd_data),
    .rd_status  (rd_status),
    .handoff    (handoff),
    .rx_data    (rx_data),
    .data_ready (data_ready),
    .overrun_err(overrun_err),
    .parity_err (parity_err),
    .framing_err(framing_err)
);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
    localparam int BIT_CLKS = 32;  // 16 ticks, tick every other clock

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun_err, parity_err, framing_err;

    int errs = 0;
    int checks = 0;

    uart_rx_core uut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .data_ready(data_ready), .overrun_err(overrun_err),
        .parity_err(parity_err), .framing_err(framing_err)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick16 <= ~tick16;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic idle(input int nbits);
        rxd = 1'b1;
        repeat (nbits * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                              input logic podd, input logic flip, input logic stopv);
        logic [7:0] dm;
        dm = d & (8'hFF >> (8 - nb));
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(dm[i]);
        if (pen) drive_bit((^dm) ^ podd ^ flip);
        drive_bit(stopv);
        idle(1);
    endtask

    task automatic pulse_reads(input logic rdd, input logic rds);
        @(negedge clk);
        rd_data = rdd;
        rd_status = rds;
        @(negedge clk);
        rd_data = 1'b0;
        rd_status = 1'b0;
    endtask

    task automatic set_cfg(input int nb, input logic pen, input logic podd);
        cfg_len = 2'(nb - 5);
        cfg_par_en = pen;
        cfg_par_odd = podd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [6];
        logic [7:0] exp_d;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rx_data", 32'(rx_data), 32'h0);
        check("R1 flags", {28'h0, data_ready, overrun_err, parity_err, framing_err}, 32'h0);
        idle(2);

        // R3 R4 R6: sweep over length, parity mode and patterns
        for (int nb = 5; nb <= 8; nb++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int p = 0; p < 6; p++) begin
                    logic [7:0] d;
                    d = pats[p] ^ 8'(p * 37 + nb);
                    set_cfg(nb, pm[1], pm[0]);
                    idle(1);
                    send_frame(d, nb, pm[1], pm[0], 1'b0, 1'b1);
                    exp_d = d & (8'hFF >> (8 - nb));
                    check("R3 data", 32'(rx_data), 32'(exp_d));
                    check("R4 ready set", 32'(data_ready), 32'h1);
                    check("R6 no parity error", 32'(parity_err), 32'h0);
                    check("R7 no framing error", 32'(framing_err), 32'h0);
                    pulse_reads(1'b1, 1'b0);
                    check("R4 ready cleared by read", 32'(data_ready), 32'h0);
                end
            end
        end

        // R6: parity mismatch, even and odd
        for (int po = 0; po < 2; po++) begin
            set_cfg(8, 1'b1, po[0]);
            idle(1);
            send_frame(8'h3C, 8, 1'b1, po[0], 1'b1, 1'b1);
            check("R6 parity error", 32'(parity_err), 32'h1);
            check("R6 data kept", 32'(rx_data), 32'h3C);
            // R8: error stays across a good frame until status read
            send_frame(8'h11, 8, 1'b1, po[0], 1'b0, 1'b1);
            check("R8 parity sticky", 32'(parity_err), 32'h1);
            pulse_reads(1'b1, 1'b1);
            check("R8 parity cleared", 32'(parity_err), 32'h0);
        end

        // R6: parity disabled, flipped bit becomes stop -> nothing extra expected
        set_cfg(7, 1'b0, 1'b0);
        idle(1);
        send_frame(8'h55, 7, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 disabled no error", 32'(parity_err), 32'h0);
        pulse_reads(1'b1, 1'b1);

        // R7: stop bit low
        set_cfg(6, 1'b0, 1'b0);
        idle(1);
        send_frame(8'h2B, 6, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 framing error", 32'(framing_err), 32'h1);
        check("R7 data", 32'(rx_data), 32'h2B);
        pulse_reads(1'b1, 1'b1);
        check("R8 framing cleared", 32'(framing_err), 32'h0);
        idle(2);
        send_frame(8'h1D, 6, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 recovery data", 32'(rx_data), 32'h1D);
        check("R7 recovery no error", 32'(framing_err), 32'h0);
        pulse_reads(1'b1, 1'b0);

        // R5: overrun
        set_cfg(8, 1'b0, 1'b0);
        idle(1);
        send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 no overrun yet", 32'(overrun_err), 32'h0);
        send_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 overrun", 32'(overrun_err), 32'h1);
        check("R5 newer data", 32'(rx_data), 32'h96);
        pulse_reads(1'b0, 1'b1);
        check("R8 overrun cleared", 32'(overrun_err), 32'h0);
        check("R4 status read keeps ready", 32'(data_ready), 32'h1);
        pulse_reads(1'b1, 1'b0);
        check("R4 ready cleared", 32'(data_ready), 32'h0);

        // R2: short low spike rejected, then normal frame
        idle(1);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        idle(3);
        check("R2 spike ignored", 32'(data_ready), 32'h0);
        check("R2 spike no errors", {29'h0, overrun_err, parity_err, framing_err}, 32'h0);
        send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 frame after spike", 32'(rx_data), 32'h6E);
        check("R2 ready after spike", 32'(data_ready), 32'h1);
        pulse_reads(1'b1, 1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule